// File: doc/BRIEF.md
# I2C SCL Clock Divider with Standard and Fast Timing

This block produces the SCL waveform and two SDA timing strobes for an I2C master. It runs from the module input clock. A 12-bit divider value `n` comes in as two fields: a 7-bit low part and a 5-bit high part. A mode bit selects standard or fast timing. In standard mode one SCL period lasts 2·(n−1)+7 input clocks. In fast mode it lasts 3·(n−1)+9 input clocks.

The high phase lasts n+2 input clocks in both modes, and the low phase takes the rest of the period. Standard mode therefore splits the period roughly in half. Fast mode gives about two thirds of the period to the low phase. One strobe marks the middle of each low phase, where SDA may change. Another marks the middle of each high phase, where SDA is sampled. A slave can stretch the clock: while SCL is released but reads low, the high phase does not advance.

A 3-bit code gives the band of the input clock. The lowest band (code 0) is too slow for fast timing. The divider stops and releases SCL in three cases: the enable input is low, the divider is below 2, or fast timing is requested in band 0. Sequencing of bus conditions is done elsewhere.

Top module: `i2c_scl_divgen`

## Requirements
- R1: After reset, SCL is released (`scl_o`=1) and both strobes are 0. Once `en` is sampled low on a clock edge, SCL is released from the next cycle and no strobe fires.
- R2: The divider value is n = {`div_hi`[4:0], `div_lo`[6:0]}, with `div_hi` supplying bits 11:7.
- R3: In standard mode (`fast_mode`=0), one SCL period (low phase plus high phase) is 2·(n−1)+7 input clock cycles.
- R4: In fast mode (`fast_mode`=1), one SCL period is 3·(n−1)+9 input clock cycles.
- R5: The high phase (`scl_o`=1) lasts n+2 cycles in both modes, and the low phase lasts the remainder of the period. The first low phase begins in the cycle after the divider starts running.
- R6: `sda_chg` is a one-cycle pulse, once per low phase, at low-phase cycle index floor(L/2). Index 0 is the first low cycle and L is the low-phase length.
- R7: `sda_smp` is a one-cycle pulse, once per high phase, at high-phase cycle index floor(H/2) for H = n+2 when no stretching occurs. It never fires while `scl_in` is low.
- R8: While `scl_o`=1 in the high phase and `scl_in` reads 0, the high-phase count holds. Each stretched cycle adds exactly one cycle to the high phase.
- R9: A divider value below 2 raises `cfg_err`. While `cfg_err` is high, SCL stays released and no strobe fires.
- R10: Fast mode with `clk_range`=0 raises `cfg_err`, with the same stopped behaviour as R9.
- R11: Any `clk_range` code (0 to 7) is accepted in standard mode. Codes 1 to 7 are accepted in fast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Divider run enable; low releases SCL |
| fast_mode | input | 1 | 1 selects fast timing, 0 standard |
| div_lo | input | 7 | Divider bits 6:0 |
| div_hi | input | 5 | Divider bits 11:7 |
| clk_range | input | 3 | Input clock band code, 0 = slowest band |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_o | output | 1 | 1 releases SCL, 0 drives it low |
| sda_chg | output | 1 | Strobe: SDA may change this cycle |
| sda_smp | output | 1 | Strobe: sample SDA this cycle |
| cfg_err | output | 1 | Divider or band setting not usable |

## Verification
The bench measures low and high phases in whole cycles. It does this for the smallest legal divider (n=2) and for values that need the upper divider field, in both modes. A design that dropped or misplaced `div_hi` would give periods shorter by 2·128 or 3·128 cycles. A design that mixed up the two overheads would be off by a few cycles in only one mode. Stretch tests hold SCL low partway through the high phase. A counter that kept running would make the high phase too short, and an ungated sample strobe would fire early or twice. Divider values 0 and 1, fast mode in band 0, and dropping `en` mid-phase must each leave SCL released with no strobes.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  localparam int DIV_LO_W = 7;
  localparam int DIV_HI_W = 5;
  localparam int RANGE_W  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // High phase length: shared by both modes.
  function automatic int high_cycles(input int n);
    return n + 2;
  endfunction

  // Low phase length: standard n+3 (total 2n+5), fast 2n+4 (total 3n+6).
  function automatic int low_cycles(input int n, input bit fast);
    return fast ? (2 * n + 4) : (n + 3);
  endfunction

  // Index of the mid-phase strobe.
  function automatic int mid_index(input int len);
    return len / 2;
  endfunction

endpackage

// File: rtl/i2c_scl_cfg_decode.sv
module i2c_scl_cfg_decode #(
  parameter int LO_W      = 7,
  parameter int HI_W      = 5,
  parameter int RNG_W     = 3,
  parameter int MIN_DIV   = 2,
  parameter int FAST_RNG  = 1,
  localparam int DIV_W    = LO_W + HI_W,
  localparam int LEN_W    = DIV_W + 2
) (
  input  logic [LO_W-1:0]  div_lo,
  input  logic [HI_W-1:0]  div_hi,
  input  logic             fast_mode,
  input  logic [RNG_W-1:0] clk_range,
  output logic             bad_cfg,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len
);
  import i2c_scl_pkg::*;

  logic [DIV_W-1:0] div_n;
  logic             div_small;
  logic             band_slow;

  assign div_n     = {div_hi, div_lo};
  assign div_small = (int'(div_n) < MIN_DIV);
  assign band_slow = fast_mode && (int'(clk_range) < FAST_RNG);
  assign bad_cfg   = div_small || band_slow;

  assign low_len   = LEN_W'(low_cycles(int'(div_n), fast_mode));
  assign high_len  = LEN_W'(high_cycles(int'(div_n)));

endmodule

// File: rtl/i2c_scl_phase_ctr.sv
module i2c_scl_phase_ctr #(
  parameter int LEN_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_ok,
  input  logic                    scl_in,
  input  logic [LEN_W-1:0]        low_len,
  input  logic [LEN_W-1:0]        high_len,
  output i2c_scl_pkg::scl_phase_e phase,
  output logic [LEN_W-1:0]        cnt
);
  import i2c_scl_pkg::*;

  logic low_done;
  logic high_done;
  logic stretched;

  assign low_done  = (cnt >= low_len - 1'b1);
  assign high_done = (cnt >= high_len - 1'b1);
  assign stretched = !scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!run_ok) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: begin
          if (low_done) begin
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (stretched) begin
            cnt <= cnt;
          end else if (high_done) begin
            phase <= PH_LOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_scl_strobe_gen.sv
module i2c_scl_strobe_gen #(
  parameter int LEN_W = 14
) (
  input  i2c_scl_pkg::scl_phase_e phase,
  input  logic [LEN_W-1:0]        cnt,
  input  logic [LEN_W-1:0]        low_len,
  input  logic [LEN_W-1:0]        high_len,
  input  logic                    scl_in,
  output logic                    scl_o,
  output logic                    sda_chg,
  output logic                    sda_smp
);
  import i2c_scl_pkg::*;

  logic [LEN_W-1:0] low_mid;
  logic [LEN_W-1:0] high_mid;

  assign low_mid  = LEN_W'(mid_index(int'(low_len)));
  assign high_mid = LEN_W'(mid_index(int'(high_len)));

  assign scl_o   = (phase != PH_LOW);
  assign sda_chg = (phase == PH_LOW) && (cnt == low_mid);
  assign sda_smp = (phase == PH_HIGH) && scl_in && (cnt == high_mid);

endmodule

// File: rtl/i2c_scl_divgen.sv
module i2c_scl_divgen #(
  parameter int LO_W     = i2c_scl_pkg::DIV_LO_W,
  parameter int HI_W     = i2c_scl_pkg::DIV_HI_W,
  parameter int RNG_W    = i2c_scl_pkg::RANGE_W,
  parameter int MIN_DIV  = 2,
  parameter int FAST_RNG = 1,
  localparam int DIV_W   = LO_W + HI_W,
  localparam int LEN_W   = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_mode,
  input  logic [LO_W-1:0]  div_lo,
  input  logic [HI_W-1:0]  div_hi,
  input  logic [RNG_W-1:0] clk_range,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             sda_chg,
  output logic             sda_smp,
  output logic             cfg_err
);
  import i2c_scl_pkg::*;

  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] cnt;
  scl_phase_e       phase;
  logic             run_ok;
  logic             in_high;

  i2c_scl_cfg_decode #(
    .LO_W(LO_W), .HI_W(HI_W), .RNG_W(RNG_W),
    .MIN_DIV(MIN_DIV), .FAST_RNG(FAST_RNG)
  ) u_cfg (
    .div_lo(div_lo), .div_hi(div_hi), .fast_mode(fast_mode),
    .clk_range(clk_range), .bad_cfg(cfg_err),
    .low_len(low_len), .high_len(high_len)
  );

  assign run_ok  = en && !cfg_err;
  assign in_high = (phase == PH_HIGH);

  i2c_scl_phase_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .scl_in(scl_in),
    .low_len(low_len), .high_len(high_len), .phase(phase), .cnt(cnt)
  );

  i2c_scl_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .phase(phase), .cnt(cnt), .low_len(low_len), .high_len(high_len),
    .scl_in(scl_in), .scl_o(scl_o), .sda_chg(sda_chg), .sda_smp(sda_smp)
  );

endmodule

// File: rtl/i2c_scl_divgen_chk.sv
module i2c_scl_divgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_o,
  input logic sda_chg,
  input logic sda_smp,
  input logic cfg_err,
  input logic in_high
);

  a_r1_off_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !sda_chg && !sda_smp));

  a_r9_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (scl_o && !sda_chg && !sda_smp));

  a_r6_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |-> !scl_o);

  a_r7_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_smp |-> (scl_o && scl_in));

  a_r8_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_in && en && !cfg_err) |=> in_high);

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_chg, sda_smp}));

endmodule

bind i2c_scl_divgen i2c_scl_divgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .scl_o(scl_o),
  .sda_chg(sda_chg), .sda_smp(sda_smp), .cfg_err(cfg_err), .in_high(in_high)
);

// File: tb/sim_i2c_scl_divgen.sv
module sim_i2c_scl_divgen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       fast_mode = 1'b0;
  logic [6:0] div_lo = 7'd4;
  logic [4:0] div_hi = 5'd0;
  logic [2:0] clk_range = 3'd2;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_o, sda_chg, sda_smp, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  assign scl_in = scl_o & ~stretch;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_divgen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fast_mode(fast_mode),
    .div_lo(div_lo), .div_hi(div_hi), .clk_range(clk_range),
    .scl_in(scl_in), .scl_o(scl_o), .sda_chg(sda_chg),
    .sda_smp(sda_smp), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int n, input bit fast);
    if (fast) return 3 * (n - 1) + 9;
    return 2 * (n - 1) + 7;
  endfunction

  function automatic int exp_high(input int n);
    return n + 2;
  endfunction

  task automatic set_div(input int n);
    div_lo = n[6:0];
    div_hi = n[11:7];
  endtask

  task automatic go_idle();
    @(negedge clk);
    en = 1'b0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Measure one low phase followed by one high phase, sampled at negedges.
  task automatic measure(input int sn, output int lo, output int hi,
                         output int chg_i, output int chg_n,
                         output int smp_i, output int smp_n);
    int guard;
    lo = 0; hi = 0; chg_i = -1; chg_n = 0; smp_i = -1; smp_n = 0;
    guard = 0;
    while (scl_o == 1'b1 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    while (scl_o == 1'b0 && guard < 20000) begin
      if (sda_chg) begin chg_i = lo; chg_n++; end
      if (sda_smp) smp_n++;
      lo++;
      @(negedge clk); guard++;
    end
    while (scl_o == 1'b1 && guard < 20000) begin
      if (sda_smp) begin smp_i = hi; smp_n++; end
      if (sda_chg) chg_n++;
      hi++;
      if (sn > 0 && hi == 2) stretch = 1'b1;
      if (sn > 0 && hi == 2 + sn) stretch = 1'b0;
      @(negedge clk); guard++;
    end
  endtask

  task automatic run_period(input int n, input bit fast, input int rng,
                            input string req, input int periods);
    int lo, hi, ci, cn, si, sn;
    int p, h, l;
    go_idle();
    set_div(n); fast_mode = fast; clk_range = rng[2:0];
    en = 1'b1;
    p = exp_period(n, fast); h = exp_high(n); l = p - h;
    for (int k = 0; k < periods; k++) begin
      measure(0, lo, hi, ci, cn, si, sn);
      chk(lo + hi == p, {req, " period"}, lo + hi, p);
      chk(hi == h, "R5 high phase", hi, h);
      chk(lo == l, "R5 low phase", lo, l);
      chk(ci == l / 2 && cn == 1, "R6 change strobe index", ci, l / 2);
      chk(si == h / 2 && sn == 1, "R7 sample strobe index", si, h / 2);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 reset scl released", scl_o, 1);
    chk(!sda_chg && !sda_smp, "R1 reset strobes", {sda_chg, sda_smp}, 0);
  endtask

  task automatic t_stretch(input int n, input int s);
    int lo, hi, ci, cn, si, sn;
    go_idle();
    set_div(n); fast_mode = 1'b0; clk_range = 3'd2;
    en = 1'b1;
    measure(s, lo, hi, ci, cn, si, sn);
    chk(hi == exp_high(n) + s, "R8 stretched high length", hi, exp_high(n) + s);
    chk(sn == 1, "R7 single sample strobe under stretch", sn, 1);
    measure(0, lo, hi, ci, cn, si, sn);
    chk(hi == exp_high(n), "R8 unstretched high after", hi, exp_high(n));
  endtask

  task automatic t_disable();
    int seen;
    go_idle();
    set_div(6); fast_mode = 1'b0; clk_range = 3'd2;
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_o == 1'b0, "R5 low after start", scl_o, 0);
    en = 1'b0;
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!scl_o || sda_chg || sda_smp) seen++;
    end
    chk(seen == 0, "R1 disabled stays released", seen, 0);
  endtask

  task automatic t_bad_cfg(input int n, input bit fast, input int rng, input string req);
    int seen;
    go_idle();
    set_div(n); fast_mode = fast; clk_range = rng[2:0];
    en = 1'b1;
    #1;
    chk(cfg_err == 1'b1, {req, " cfg_err"}, cfg_err, 1);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!scl_o || sda_chg || sda_smp) seen++;
    end
    chk(seen == 0, {req, " stopped and released"}, seen, 0);
  endtask

  task automatic t_range_ok();
    go_idle();
    set_div(5); fast_mode = 1'b0; clk_range = 3'd0;
    #1;
    chk(cfg_err == 1'b0, "R11 std band 0 accepted", cfg_err, 0);
    for (int r = 1; r < 8; r++) begin
      fast_mode = 1'b1; clk_range = r[2:0];
      #1;
      chk(cfg_err == 1'b0, "R11 fast band accepted", cfg_err, 0);
    end
    run_period(5, 1'b0, 0, "R11 std band 0", 1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_period(4, 1'b0, 2, "R3 std n=4", 2);
    run_period(2, 1'b0, 2, "R3 std min n=2", 1);
    run_period(133, 1'b0, 2, "R2 R3 std n=133", 1);
    run_period(4, 1'b1, 3, "R4 fast n=4", 2);
    run_period(133, 1'b1, 7, "R2 R4 fast n=133", 1);
    run_period(1029, 1'b0, 5, "R2 upper field n=1029", 1);
    t_stretch(4, 5);
    t_stretch(9, 1);
    t_disable();
    t_bad_cfg(1, 1'b0, 2, "R9 n=1");
    t_bad_cfg(0, 1'b0, 2, "R9 n=0");
    t_bad_cfg(128, 1'b1, 0, "R10 fast band 0");
    t_range_ok();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule